// File: doc/BRIEF.md
# Queued Word DMA Engine with Loopback

This block moves 32-bit words out of memory on behalf of software. Software programs a source address, a destination address, a source length and a destination length. The write to the destination length register captures all four values into a small in-order command queue. The engine takes the oldest queued command and reads its source words in bursts. Each burst is held in a local buffer.

In loopback mode, each burst read is written back to the destination address once the read completes. Outside loopback, the words are only read; their consumer is outside this block. When a command finishes, two done flags are raised in a write-one-to-clear interrupt status register. A mask register gates these flags onto a single interrupt line.

The register bus is a simple 32-bit write strobe with a combinational read path. The memory side moves one word per request/acknowledge handshake.

Top module: `loopdma`

## Requirements
- R1: After reset, the status register (0x14) reads 0x40000000, with bit 30 meaning queue empty and bit 31 meaning queue full. The interrupt mask (0x10) reads 0xFFFFFFFF, the interrupt status (0x0C) reads 0, and `irq` is low.
- R2: The source length (0x20) and destination length (0x24) registers keep only bits 26:0, and their upper bits read as zero.
- R3: A write to 0x24 enqueues one command built from the source address (0x18), the destination address (0x1C), the source length and the newly written destination length. Lengths count words. Address bits 1:0 are cleared in the queued command. Commands execute in the order they were queued.
- R4: A burst is at most 256 words (1 KiB) long. It is also limited by the remaining source length, and in loopback by the remaining destination length.
- R5: Loopback is bit 4 of the mode register (0x80) and is sampled at the start of each burst. In loopback, the words of a burst are written in order to consecutive destination words after the burst's reads. Without loopback, no memory write is issued.
- R6: Each memory access is a single word. `memReq`, `memWe`, `memAddr` and `memWdata` stay stable until `memAck`. A burst's writes, or the next burst's reads, start only after the current burst's accesses are all acknowledged.
- R7: A command retires when its next burst would be zero words, including a command that is empty from the start. Retiring sets status bits 13 (done) and 12 (partial done) and removes the command from the queue. A command occupies the queue until it retires.
- R8: The queue holds 4 commands, counting the one executing. The full and empty status bits follow the occupancy and are never both set.
- R9: A write to 0x24 while the queue is full is dropped and sets status bit 14 (overflow).
- R10: Writing a 1 to a bit of register 0x0C clears that bit, and a set in the same cycle takes priority over the clear. `irq` is the OR of the status bits whose mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset, used for both read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Handshake completes on a cycle with `memReq` and `memAck` |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check on every cycle that:
- a pending memory request holds its direction, address and data until acknowledged;
- the queue never reports full and empty together;
- no memory request is made while the queue is empty;
- every retirement raises both done flags;
- every push into a full queue raises the overflow flag.

Burst sizes, the ordering of reads before loopback writes, word alignment of queued addresses, dropped commands and interrupt masking can only be shown by the bench's scenarios. There, a scoreboard predicts the exact sequence of memory handshakes for each command.

// File: rtl/loopdma_pkg.sv
package loopdma_pkg;
  localparam logic [7:0] OFS_INTSTS = 8'h0C;
  localparam logic [7:0] OFS_MASK   = 8'h10;
  localparam logic [7:0] OFS_STATUS = 8'h14;
  localparam logic [7:0] OFS_SADDR  = 8'h18;
  localparam logic [7:0] OFS_DADDR  = 8'h1C;
  localparam logic [7:0] OFS_SLEN   = 8'h20;
  localparam logic [7:0] OFS_DLEN   = 8'h24;
  localparam logic [7:0] OFS_MODE   = 8'h80;

  localparam int STS_LSB        = 12;  // pdone=12, done=13, overflow=14
  localparam int STAT_FULL_BIT  = 31;
  localparam int STAT_EMPTY_BIT = 30;
  localparam int MODE_LOOP_BIT  = 4;

  typedef struct packed {
    logic loadCmd;
    logic capture;
    logic stepSrc;
    logic stepDst;
    logic retire;
  } dmaStrobe_t;
endpackage

// File: rtl/loopdma_ctrl.sv
module loopdma_ctrl import loopdma_pkg::*; #(
  parameter int BURST_WORDS = 256,
  localparam int IDX_W = $clog2(BURST_WORDS),
  localparam int CNT_W = IDX_W + 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             qEmpty,
  input  logic             loopMode,
  input  logic [CNT_W-1:0] burstWords,
  input  logic             memAck,
  output logic             memReq,
  output logic             memWe,
  output logic [IDX_W-1:0] bufIdx,
  output dmaStrobe_t       stb
);
  typedef enum logic [1:0] {ST_IDLE, ST_PLAN, ST_READ, ST_WRITE} state_t;
  state_t state;
  logic [IDX_W-1:0] idx, lastIdx;
  logic burstLoop;

  assign bufIdx = idx;

  always_comb begin
    stb    = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    case (state)
      ST_IDLE: stb.loadCmd = !qEmpty;
      ST_PLAN: stb.retire  = (burstWords == '0);
      ST_READ: begin
        memReq      = 1'b1;
        stb.capture = memAck;
        stb.stepSrc = memAck;
      end
      default: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        stb.stepDst = memAck;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      lastIdx   <= '0;
      burstLoop <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (!qEmpty) state <= ST_PLAN;
        ST_PLAN: begin
          if (burstWords == '0) begin
            state <= ST_IDLE;
          end else begin
            lastIdx   <= IDX_W'(burstWords - 1'b1);
            burstLoop <= loopMode;
            idx       <= '0;
            state     <= ST_READ;
          end
        end
        ST_READ: if (memAck) begin
          if (idx == lastIdx) begin
            idx   <= '0;
            state <= burstLoop ? ST_WRITE : ST_PLAN;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: if (memAck) begin
          if (idx == lastIdx) state <= ST_PLAN;
          else idx <= idx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/loopdma_data.sv
module loopdma_data import loopdma_pkg::*; #(
  parameter int QDEPTH = 4,
  parameter int BURST_WORDS = 256,
  parameter int LEN_W = 27,
  localparam int IDX_W = $clog2(BURST_WORDS),
  localparam int CNT_W = IDX_W + 1,
  localparam int QPTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  dmaStrobe_t       stb,
  input  logic [IDX_W-1:0] bufIdx,
  input  logic             memWe,
  input  logic [31:0]      memRdata,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWdata,
  output logic [CNT_W-1:0] burstWords,
  output logic             loopMode,
  output logic             qEmpty,
  output logic             qFull,
  output logic [2:0]       stsBits,
  output logic [2:0]       maskBits
);
  typedef struct packed {
    logic [29:0]      src;
    logic [29:0]      dst;
    logic [LEN_W-1:0] sLen;
    logic [LEN_W-1:0] dLen;
  } cmd_t;

  localparam logic [LEN_W-1:0] CAP = LEN_W'(BURST_WORDS);

  logic [31:0] srcAddrReg, dstAddrReg, intMask;
  logic [LEN_W-1:0] srcLenReg, dstLenReg;
  logic [2:0] intSts, stsNext;
  cmd_t qMem [QDEPTH];
  logic [QPTR_W-1:0] wrPtr, rdPtr;
  logic [QPTR_W:0] qCount;
  logic [29:0] curSrc, curDst;
  logic [LEN_W-1:0] curSrcRem, curDstRem, lim1, lim2;
  logic [31:0] burstBuf [BURST_WORDS];
  logic push, doPush, drop, w1c;

  function automatic logic [QPTR_W-1:0] nextPtr(input logic [QPTR_W-1:0] p);
    return (p == QPTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push   = regWe && (regAddr == OFS_DLEN);
  assign doPush = push && !qFull;
  assign drop   = push && qFull;
  assign w1c    = regWe && (regAddr == OFS_INTSTS);
  assign qEmpty = (qCount == '0);
  assign qFull  = (qCount == (QPTR_W+1)'(QDEPTH));

  assign stsNext  = (intSts & ~(w1c ? regWdata[STS_LSB +: 3] : 3'b000))
                  | {drop, stb.retire, stb.retire};
  assign stsBits  = intSts;
  assign maskBits = intMask[STS_LSB +: 3];

  always_comb begin
    lim1 = (curSrcRem < CAP) ? curSrcRem : CAP;
    lim2 = (loopMode && (curDstRem < lim1)) ? curDstRem : lim1;
    burstWords = lim2[CNT_W-1:0];
  end

  assign memAddr  = {memWe ? curDst : curSrc, 2'b00};
  assign memWdata = burstBuf[bufIdx];

  always_comb begin
    case (regAddr)
      OFS_INTSTS: regRdata = 32'(intSts) << STS_LSB;
      OFS_MASK:   regRdata = intMask;
      OFS_STATUS: regRdata = (32'(qFull) << STAT_FULL_BIT) | (32'(qEmpty) << STAT_EMPTY_BIT);
      OFS_SADDR:  regRdata = srcAddrReg;
      OFS_DADDR:  regRdata = dstAddrReg;
      OFS_SLEN:   regRdata = 32'(srcLenReg);
      OFS_DLEN:   regRdata = 32'(dstLenReg);
      OFS_MODE:   regRdata = 32'(loopMode) << MODE_LOOP_BIT;
      default:    regRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (doPush) qMem[wrPtr] <= '{src: srcAddrReg[31:2], dst: dstAddrReg[31:2],
                                 sLen: srcLenReg, dLen: regWdata[LEN_W-1:0]};
    if (stb.capture) burstBuf[bufIdx] <= memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddrReg <= '0;
      dstAddrReg <= '0;
      srcLenReg  <= '0;
      dstLenReg  <= '0;
      intMask    <= '1;
      loopMode   <= 1'b0;
      intSts     <= '0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      qCount     <= '0;
      curSrc     <= '0;
      curDst     <= '0;
      curSrcRem  <= '0;
      curDstRem  <= '0;
    end else begin
      if (regWe) begin
        case (regAddr)
          OFS_SADDR: srcAddrReg <= regWdata;
          OFS_DADDR: dstAddrReg <= regWdata;
          OFS_SLEN:  srcLenReg  <= regWdata[LEN_W-1:0];
          OFS_DLEN:  dstLenReg  <= regWdata[LEN_W-1:0];
          OFS_MASK:  intMask    <= regWdata;
          OFS_MODE:  loopMode   <= regWdata[MODE_LOOP_BIT];
          default: ;
        endcase
      end
      intSts <= stsNext;
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (stb.retire) rdPtr <= nextPtr(rdPtr);
      case ({doPush, stb.retire})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: ;
      endcase
      if (stb.loadCmd) begin
        curSrc    <= qMem[rdPtr].src;
        curDst    <= qMem[rdPtr].dst;
        curSrcRem <= qMem[rdPtr].sLen;
        curDstRem <= qMem[rdPtr].dLen;
      end else begin
        if (stb.stepSrc) begin
          curSrc    <= curSrc + 1'b1;
          curSrcRem <= curSrcRem - 1'b1;
        end
        if (stb.stepDst) begin
          curDst    <= curDst + 1'b1;
          curDstRem <= curDstRem - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/loopdma.sv
module loopdma import loopdma_pkg::*; #(
  parameter int QDEPTH = 4,
  parameter int BURST_WORDS = 256,
  parameter int LEN_W = 27,
  localparam int IDX_W = $clog2(BURST_WORDS),
  localparam int CNT_W = IDX_W + 1
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  output logic        irq
);
  dmaStrobe_t       stb;
  logic [IDX_W-1:0] bufIdx;
  logic [CNT_W-1:0] burstWords;
  logic             loopMode, qEmpty, qFull;
  logic [2:0]       stsBits, maskBits;

  loopdma_ctrl #(.BURST_WORDS(BURST_WORDS)) i_ctrl (
    .clk, .rstN, .qEmpty, .loopMode, .burstWords, .memAck,
    .memReq, .memWe, .bufIdx, .stb
  );

  loopdma_data #(.QDEPTH(QDEPTH), .BURST_WORDS(BURST_WORDS), .LEN_W(LEN_W)) i_data (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .regRdata, .stb, .bufIdx,
    .memWe, .memRdata, .memAddr, .memWdata, .burstWords, .loopMode,
    .qEmpty, .qFull, .stsBits, .maskBits
  );

  assign irq = |(stsBits & ~maskBits);
endmodule

// File: rtl/loopdma_chk.sv
module loopdma_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [7:0]  regAddr,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata,
  input logic        memAck,
  input logic        qEmpty,
  input logic        qFull,
  input logic        retire,
  input logic [2:0]  stsBits
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata))); // R6
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(qFull && qEmpty)); // R8
  AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    qEmpty |-> !memReq); // R7
  AST_RETIRE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    retire |=> (stsBits[1] && stsBits[0])); // R7
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (regAddr == 8'h24) && qFull) |=> stsBits[2]); // R9
endmodule

bind loopdma loopdma_chk i_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
  .memAck(memAck), .qEmpty(qEmpty), .qFull(qFull), .retire(stb.retire),
  .stsBits(stsBits)
);

// File: tb/test_loopdma.sv
module test_loopdma;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic memReq, memWe, irq;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [31:0] mem [16384];
  logic [31:0] expRdQ [$];
  logic [63:0] expWrQ [$];

  always #10 clk = ~clk;  // 50 MHz

  loopdma i_loopdma (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .regRdata,
    .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memAck, .irq
  );

  // memory model: acknowledges one cycle after a request appears
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
    end else if (memReq && !memAck) begin
      memAck <= 1'b1;
      memRdata <= mem[memAddr[15:2]];
    end else begin
      memAck <= 1'b0;
      if (memReq && memAck && memWe) mem[memAddr[15:2]] <= memWdata;
    end
  end

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: a handshake completes at the next rising edge
  always @(negedge clk) begin
    if (rstN && memReq && memAck) begin
      if (memWe) begin
        if (expWrQ.size() == 0) begin
          checkEq("R5", "unexpected write addr", memAddr, 32'hFFFFFFFF);
        end else begin
          logic [63:0] e;
          e = expWrQ.pop_front();
          checkEq("R5", "write addr", memAddr, e[63:32]);
          checkEq("R6", "write data", memWdata, e[31:0]);
        end
      end else begin
        if (expRdQ.size() == 0) begin
          checkEq("R3", "unexpected read addr", memAddr, 32'hFFFFFFFF);
        end else begin
          logic [31:0] a;
          a = expRdQ.pop_front();
          checkEq("R4", "read addr", memAddr, a);
        end
      end
    end
  end

  // driver: predicts every handshake of one command
  task automatic expectCmd(input logic [31:0] src, input logic [31:0] dst,
                           input int sLen, input int dLen, input bit loop);
    int s = int'(src >> 2);
    int d = int'(dst >> 2);
    int sr = sLen;
    int dr = dLen;
    forever begin
      int n = (sr < 256) ? sr : 256;
      if (loop && dr < n) n = dr;
      if (n == 0) break;
      for (int i = 0; i < n; i++) expRdQ.push_back(32'((s + i) << 2));
      if (loop)
        for (int i = 0; i < n; i++) expWrQ.push_back({32'((d + i) << 2), mem[s + i]});
      s += n; sr -= n;
      if (loop) begin d += n; dr -= n; end
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    regAddr = a; regWdata = v; regWe = 1'b1;
    @(posedge clk);
    #1 regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic sendCmd(input logic [31:0] src, input logic [31:0] dst,
                         input int sLen, input int dLen, input bit loop);
    expectCmd(src, dst, sLen, dLen, loop);
    regWrite(8'h18, src);
    regWrite(8'h1C, dst);
    regWrite(8'h20, 32'(sLen));
    regWrite(8'h24, 32'(dLen));
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    forever begin
      regRead(8'h14, v);
      if (v[30] && expRdQ.size() == 0 && expWrQ.size() == 0) break;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v, old;
    for (int i = 0; i < 16384; i++) mem[i] = 32'hA5000000 ^ (32'(i) * 32'h00019E37);
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    regRead(8'h14, v); checkEq("R1", "status", v, 32'h40000000);
    regRead(8'h10, v); checkEq("R1", "mask", v, 32'hFFFFFFFF);
    regRead(8'h0C, v); checkEq("R1", "intsts", v, 32'h0);
    checkEq("R1", "irq", 32'(irq), 32'h0);

    // R2 length width
    regWrite(8'h20, 32'hFFFFFFFF);
    regRead(8'h20, v); checkEq("R2", "srclen", v, 32'h07FFFFFF);

    // R3/R5 loopback copy with unaligned destination
    regWrite(8'h80, 32'h10);
    regRead(8'h80, v); checkEq("R5", "mode", v, 32'h10);
    sendCmd(32'h100, 32'h2003, 5, 5, 1);
    waitIdle();
    checkEq("R3", "copied word 4", mem[32'h2000/4 + 4], mem[32'h100/4 + 4]);
    regRead(8'h0C, v); checkEq("R7", "done bits", v, 32'h00003000);
    checkEq("R10", "irq masked", 32'(irq), 32'h0);
    regWrite(8'h10, 32'h0);
    regRead(8'h0C, v); checkEq("R10", "irq unmasked", 32'(irq), 32'h1);
    regWrite(8'h0C, 32'h1000);
    regRead(8'h0C, v); checkEq("R10", "w1c one bit", v, 32'h00002000);
    checkEq("R10", "irq still", 32'(irq), 32'h1);
    regWrite(8'h0C, 32'h2000);
    regRead(8'h0C, v); checkEq("R10", "w1c rest", v, 32'h0);
    checkEq("R10", "irq low", 32'(irq), 32'h0);

    // R5 no loopback: reads only, destination untouched
    regWrite(8'h80, 32'h0);
    old = mem[32'h3000/4];
    sendCmd(32'h200, 32'h3000, 3, 3, 0);
    waitIdle();
    checkEq("R5", "dst untouched", mem[32'h3000/4], old);
    regRead(8'h0C, v); checkEq("R7", "done nonloop", v, 32'h00003000);
    regWrite(8'h0C, 32'h7000);

    // R4 burst cap: 300 words split 256 + 44
    regWrite(8'h80, 32'h10);
    sendCmd(32'h1000, 32'h8000, 300, 300, 1);
    waitIdle();
    checkEq("R4", "last copied word", mem[32'h8000/4 + 299], mem[32'h1000/4 + 299]);
    regWrite(8'h0C, 32'h7000);

    // R4 destination-limited loopback
    old = mem[32'h5000/4 + 2];
    sendCmd(32'h2000, 32'h5000, 4, 2, 1);
    waitIdle();
    checkEq("R4", "dst limit word 2", mem[32'h5000/4 + 2], old);
    regRead(8'h0C, v); checkEq("R7", "done dst-limited", v, 32'h00003000);
    regWrite(8'h0C, 32'h7000);

    // R7 empty command retires with no traffic
    sendCmd(32'h2400, 32'h5400, 0, 3, 1);
    waitIdle();
    regRead(8'h0C, v); checkEq("R7", "done empty cmd", v, 32'h00003000);
    regWrite(8'h0C, 32'h7000);

    // R8/R9 queue fill and overflow
    regWrite(8'h80, 32'h0);
    regWrite(8'h18, 32'h600);
    regWrite(8'h1C, 32'h6000);
    regWrite(8'h20, 32'd10);
    for (int k = 0; k < 4; k++) expectCmd(32'h600, 32'h6000, 10, 10, 0);
    for (int k = 0; k < 4; k++) regWrite(8'h24, 32'd10);
    regRead(8'h14, v); checkEq("R8", "full", v, 32'h80000000);
    regWrite(8'h24, 32'd10);
    regRead(8'h0C, v); checkEq("R9", "overflow", v & 32'h4000, 32'h4000);
    waitIdle();
    regRead(8'h14, v); checkEq("R8", "empty again", v, 32'h40000000);

    checkEq("R3", "leftover reads", 32'(expRdQ.size()), 32'h0);
    checkEq("R5", "leftover writes", 32'(expWrQ.size()), 32'h0);
    summary();
  end
endmodule